// File: doc/BRIEF.md
# Auxiliary Register Window and Work-RAM Decoder

This block sits on the CPU write side of a cartridge bank-switching controller. It watches two places in the CPU address map. The first is a window in the `$5000-$5FFF` page that holds four auxiliary control bytes: a mode byte, a PRG base, a CHR base and an extended-mode byte. A 3-bit board switch input sets which address bit must be high for the window to decode. The second is the `$A001` location, which holds a RAM configuration byte.

The configuration byte acts as a plain PRG-RAM enable until its bit 5 is set. After that, it also selects one of four 8 KiB work-RAM banks. It also says whether the first 8 KiB of CHR space is RAM. It can also close the auxiliary window. While the window is closed, the whole `$5000-$5FFF` page reaches the upper 4 KiB of work-RAM bank 2 instead of the registers.

The block outputs the stored bytes, a 15-bit address into a 32 KiB work RAM, a select and a write strobe for that RAM, and a flag for the battery-backed banks. It also outputs a one-cycle clear pulse for the external CHR latch. The bank address arithmetic for PRG and CHR and the scanline counter core are outside this block.

Top module: `aux_window_decoder`

## Requirements
- R1: After reset, the mode, CHR base, extended-mode and configuration bytes read `$00`. The PRG base reads `$00`, or `$20` when `alt_boot` is high during reset.
- R2: Let `s = $0010 << sw` (sw = 0..7). A write with `cpu_wr` high loads byte k at the rising edge when the address satisfies `(addr & ($500F|s)) == ($5000|s|k)`. Byte k is mode for k=0, PRG base for 1, CHR base for 2 and extended mode for 3. Address bits outside that mask, except bits 15:12 which must be `$5`, do not matter. An address with bit `s` clear writes no register.
- R3: While configuration bit 5 = 1 and bit 6 = 0, writes to the `$5xxx` page change no auxiliary byte. Every `$5xxx` access selects work RAM at address `{3'b101, addr[11:0]}`, that is `$5000 + addr[11:0]`, whether or not bit 7 is set.
- R4: While configuration bit 5 = 0, bits 6, 2 and 1:0 have no effect. The window stays open, `chr_lo_ram` is 0, and `$6000-$7FFF` uses bank 0.
- R5: A read or write in `$6000-$7FFF` asserts `wram_sel` only when configuration bit 7 = 1. The address is `{bank, addr[12:0]}`, where bank is bits 1:0 of the configuration byte when bit 5 = 1.
- R6: A write that loads the CHR base drives `latch_clr` high for the one cycle that follows that edge. `latch_clr` is low in every other cycle.
- R7: `wram_keep` is high exactly when `wram_sel` is high and the selected bank is 1 or 3, that is when `wram_addr[13]` = 1.
- R8: `chr_lo_ram` equals configuration bit 2 while bit 5 = 1.
- R9: The configuration byte decodes under mask `$E001` at `$A001`, so `$A001` and `$BFFF` load it and `$A000` does not.
- R10: With `cpu_wr` low, nothing is stored, and with both `cpu_rd` and `cpu_wr` low, `wram_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_boot | input | 1 | Strap selecting the `$20` PRG base reset value |
| sw | input | 3 | Board switch setting for the window decode bit |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled at the rising edge |
| cpu_rd | input | 1 | Read strobe, used only for the work-RAM select |
| mode_q | output | 8 | Mode byte |
| prg_base_q | output | 8 | PRG base byte |
| chr_base_q | output | 8 | CHR base byte |
| ext_mode_q | output | 8 | Extended-mode byte |
| ram_cfg_q | output | 8 | Raw configuration byte |
| chr_lo_ram | output | 1 | First 8 KiB of CHR space is RAM |
| wram_sel | output | 1 | Work-RAM access this cycle |
| wram_we | output | 1 | Work-RAM write this cycle |
| wram_addr | output | 15 | Work-RAM byte address |
| wram_keep | output | 1 | Selected bank is battery-backed |
| latch_clr | output | 1 | One-cycle clear for the external CHR latch |

## Verification
The assertions assume that `sw` and `alt_boot` do not change while a write is in progress. They also assume that `cpu_rd` and `cpu_wr` are never high together. The bench changes the switch setting only while both strobes are low. It drives exactly one strobe per access and returns both to low between accesses. It never issues a read and a write in the same cycle.

// File: rtl/aux_window_decoder.sv
module aux_window_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alt_boot,
  input  logic [2:0]  sw,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  output logic [7:0]  mode_q,
  output logic [7:0]  prg_base_q,
  output logic [7:0]  chr_base_q,
  output logic [7:0]  ext_mode_q,
  output logic [7:0]  ram_cfg_q,
  output logic        chr_lo_ram,
  output logic        wram_sel,
  output logic        wram_we,
  output logic [14:0] wram_addr,
  output logic        wram_keep,
  output logic        latch_clr
);

  localparam int NREG = 4;
  localparam logic [7:0] PRG_ALT_RST = 8'h20;

  logic [7:0]      aux_q [NREG];
  logic [NREG-1:0] reg_hit;
  logic [15:0]     sel_bit, dec_mask, dec_base;
  logic            cfg_on, win_on, aux_area, ram_area, cfg_hit, fall, acc;
  logic [1:0]      bank;

  assign cfg_on   = ram_cfg_q[5];
  assign win_on   = !cfg_on || ram_cfg_q[6];
  assign bank     = cfg_on ? ram_cfg_q[1:0] : 2'b00;
  assign sel_bit  = 16'h0010 << sw;
  assign dec_mask = 16'h500F | sel_bit;
  assign dec_base = 16'h5000 | sel_bit;
  assign aux_area = cpu_addr[15:12] == 4'h5;
  assign ram_area = cpu_addr[15:13] == 3'b011;
  assign cfg_hit  = cpu_addr[15:13] == 3'b101 && cpu_addr[0];
  assign fall     = aux_area && !win_on;
  assign acc      = cpu_rd || cpu_wr;

  for (genvar k = 0; k < NREG; k++) begin : g_hit
    assign reg_hit[k] = aux_area && win_on &&
                        ((cpu_addr & dec_mask) == (dec_base | 16'(k)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) aux_q[k] <= 8'h00;
      if (alt_boot) aux_q[1] <= PRG_ALT_RST;
      ram_cfg_q <= 8'h00;
      latch_clr <= 1'b0;
    end else begin
      for (int k = 0; k < NREG; k++)
        if (cpu_wr && reg_hit[k]) aux_q[k] <= cpu_wdata;
      if (cpu_wr && cfg_hit) ram_cfg_q <= cpu_wdata;
      latch_clr <= cpu_wr && reg_hit[2];
    end
  end

  assign mode_q     = aux_q[0];
  assign prg_base_q = aux_q[1];
  assign chr_base_q = aux_q[2];
  assign ext_mode_q = aux_q[3];
  assign chr_lo_ram = cfg_on && ram_cfg_q[2];

  assign wram_sel  = acc && ((ram_area && ram_cfg_q[7]) || fall);
  assign wram_we   = wram_sel && cpu_wr;
  assign wram_addr = fall ? {3'b101, cpu_addr[11:0]} : {bank, cpu_addr[12:0]};
  assign wram_keep = wram_sel && wram_addr[13];

  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_hit));

  a_r3_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && aux_area && ram_cfg_q[5] && !ram_cfg_q[6]) |=>
      ($stable(mode_q) && $stable(prg_base_q) && $stable(chr_base_q) && $stable(ext_mode_q)));

  a_r3_fall_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && aux_area && ram_cfg_q[5] && !ram_cfg_q[6]) |-> (wram_sel && wram_addr[14:12] == 3'b101));

  a_r4_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wram_sel && ram_area && !ram_cfg_q[5]) |-> wram_addr[14:13] == 2'b00);

  a_r5_ram_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wram_sel && ram_area) |-> ram_cfg_q[7]);

  a_r6_clr_data: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr |-> (chr_base_q == $past(cpu_wdata) && $past(cpu_wr)));

  a_r8_chr_ram_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    chr_lo_ram |-> ram_cfg_q[5]);

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> !wram_sel && !wram_we);

endmodule

// File: tb/aux_window_decoder_tb.sv
module aux_window_decoder_tb;
  logic clk = 0, rst_n = 0, alt_boot = 0, cpu_wr = 0, cpu_rd = 0;
  logic [2:0] sw = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] mode_q, prg_base_q, chr_base_q, ext_mode_q, ram_cfg_q;
  logic chr_lo_ram, wram_sel, wram_we, wram_keep, latch_clr;
  logic [14:0] wram_addr;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  aux_window_decoder u_dut (.clk, .rst_n, .alt_boot, .sw, .cpu_addr, .cpu_wdata,
    .cpu_wr, .cpu_rd, .mode_q, .prg_base_q, .chr_base_q, .ext_mode_q, .ram_cfg_q,
    .chr_lo_ram, .wram_sel, .wram_we, .wram_addr, .wram_keep, .latch_clr);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(logic [15:0] a, logic [7:0] d, logic w, logic r);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = r;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0;
    #1;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    put(a, d, 1, 0);
    idle();
  endtask

  task automatic t_reset(logic strap);
    alt_boot = strap; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; #1;
    chk("R1 mode", mode_q, 0);
    chk("R1 prg_base", prg_base_q, strap ? 8'h20 : 8'h00);
    chk("R1 chr_base", chr_base_q, 0);
    chk("R1 ext_mode", ext_mode_q, 0);
    chk("R1 ram_cfg", ram_cfg_q, 0);
    chk("R6 clr idle", latch_clr, 0);
  endtask

  task automatic t_decode();
    for (int d = 0; d < 8; d++) begin
      logic [15:0] s;
      logic [15:0] noise;
      @(negedge clk); sw = 3'(d);
      s = 16'h0010 << d;
      noise = 16'h0FF0 & ~s & 16'h0A50;
      for (int k = 0; k < 4; k++) begin
        logic [7:0] v;
        v = 8'(8'h31 + d * 16 + k);
        wr(16'h5000 | s | noise | 16'(k), v);
        case (k)
          0: chk("R2 mode load", mode_q, v);
          1: chk("R2 prg load", prg_base_q, v);
          2: begin
               chk("R2 chr load", chr_base_q, v);
               chk("R6 clr pulse", latch_clr, 1);
               idle();
               chk("R6 clr one cycle", latch_clr, 0);
             end
          default: chk("R2 ext load", ext_mode_q, v);
        endcase
        wr(16'h5000 | (16'h0FF0 & ~s) & ~s | 16'(k), 8'hEE);
        case (k)
          0: chk("R2 miss mode", mode_q, v);
          1: chk("R2 miss prg", prg_base_q, v);
          2: chk("R2 miss chr", chr_base_q, v);
          default: chk("R2 miss ext", ext_mode_q, v);
        endcase
      end
    end
    @(negedge clk); sw = 0;
  endtask

  task automatic t_config();
    wr(16'hA000, 8'h7F);
    chk("R9 A000 ignored", ram_cfg_q, 0);
    wr(16'hA001, 8'h47);
    chk("R9 A001 load", ram_cfg_q, 8'h47);
    chk("R4 chr_lo off", chr_lo_ram, 0);
    put(16'h6123, 0, 0, 1);
    chk("R5 gated off", wram_sel, 0);
    idle();
    wr(16'hBFFF, 8'hC7);
    chk("R9 BFFF load", ram_cfg_q, 8'hC7);
    put(16'h6123, 0, 0, 1);
    chk("R5 sel on", wram_sel, 1);
    chk("R4 bank0 addr", wram_addr, 15'h0123);
    chk("R7 keep bank0", wram_keep, 0);
    idle();
    wr(16'h5010, 8'h5A);
    chk("R4 window open", mode_q, 8'h5A);
    put(16'h5010, 8'h99, 0, 0);
    chk("R10 idle sel", wram_sel, 0);
    idle();
    chk("R10 no store", mode_q, 8'h5A);
  endtask

  task automatic t_protect();
    logic [15:0] pa [3] = '{16'h5000, 16'h5010, 16'h5013};
    wr(16'hA001, 8'hA1);
    foreach (pa[i]) begin
      put(pa[i], 8'(8'h11 * (i + 1)), 1, 0);
      chk("R3 fall sel", wram_sel, 1);
      chk("R3 fall we", wram_we, 1);
      chk("R3 fall addr", wram_addr, 15'(pa[i]));
      idle();
    end
    chk("R3 mode kept", mode_q, 8'h5A);
    chk("R3 ext kept", ext_mode_q, 8'h34 + 8'h70);
    wr(16'hA001, 8'h21);
    put(16'h5ABC, 0, 0, 1);
    chk("R3 fall no bit7", wram_sel, 1);
    chk("R3 fall addr2", wram_addr, 15'h5ABC);
    idle();
    wr(16'hA001, 8'hE2);
    chk("R8 chr_lo clear", chr_lo_ram, 0);
    put(16'h6000, 0, 0, 1);
    chk("R5 bank2 addr", wram_addr, 15'h4000);
    chk("R7 keep bank2", wram_keep, 0);
    idle();
    wr(16'h5013, 8'h77);
    chk("R2 ext after open", ext_mode_q, 8'h77);
    wr(16'hA001, 8'hA7);
    chk("R8 chr_lo set", chr_lo_ram, 1);
    put(16'h7FFF, 8'h01, 1, 0);
    chk("R5 bank3 addr", wram_addr, 15'h7FFF);
    chk("R7 keep bank3", wram_keep, 1);
    idle();
    wr(16'hA001, 8'hE5);
    put(16'h6ABC, 0, 0, 1);
    chk("R5 bank1 addr", wram_addr, 15'h2ABC);
    chk("R7 keep bank1", wram_keep, 1);
    idle();
  endtask

  initial begin
    t_reset(1);
    t_reset(0);
    t_decode();
    t_config();
    t_protect();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule